// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes level reports from PCI devices and turns them into a 16-bit vector of level inputs for a legacy interrupt controller. Each report carries the device/function number, the interrupt pin (INTA to INTD) and the new level. The block rotates the pin by the device's slot number and picks one of four shared interrupt lines. It latches the level of that line, and each line is then steered to a controller input by its own 8-bit routing register.

Software programs the four routing registers through a byte-wide register port. A routing value below 16 picks a controller input. Any value of 16 or above takes the line off every output. When several lines point at the same controller input, their levels are ORed together. The outputs are combinational from the latched levels and the routing registers, so a report or a routing change shows on the outputs in the cycle after the clock edge that captured it.

Top module: `pirq_router`

## Requirements
- R1: The slot number is bits [7:3] of `evt_devfn`. The shared line index is (pin + slot − 1) mod 4, where pin 0 is INTA and pin 3 is INTD. Line indexes 0..3 correspond to routing registers 0x60..0x63.
- R2: A write with `cfg_we` high to offset 0x60, 0x61, 0x62 or 0x63 stores `cfg_wdata` into the routing register of line 0, 1, 2 or 3. Reading that offset on `cfg_rdata` returns the last value written.
- R3: A write to any offset outside 0x60..0x63 changes no routing register. A read of such an offset returns 0x00.
- R4: During and after reset, every routing register reads 0x80, every latched line level is 0, and `irq_out` is all zero.
- R5: A routing value v below 16 drives the line's level onto `irq_out[v]`. A value of 16 or above (for example 0x10 or 0x80) connects the line to no output.
- R6: Each bit of `irq_out` is the OR of the latched levels of every line routed to it. Dropping one of two such lines keeps the bit high while the other stays high.
- R7: Each line keeps one latched level. It is set to `evt_level` on every cycle where `evt_valid` is high and the report maps to that line, so the most recent report from any device on that line wins. The result appears on `irq_out` in the next cycle.
- R8: Rewriting a routing register moves the line's latched level to the new output in the next cycle. This includes a line that was disabled while its level was latched high.
- R9: `irq_out` changes only in the cycle after a report or a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A level report is present this cycle |
| evt_devfn | input | 8 | Device/function number of the reporting device |
| evt_pin | input | 2 | Interrupt pin, 0 = INTA through 3 = INTD |
| evt_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Register byte write strobe |
| cfg_addr | input | 8 | Register offset for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| irq_out | output | 16 | Level inputs to the interrupt controller |

## Verification
The hardest situation to reach is a level that becomes visible only through a routing change. The stimulus raises a line while its register still holds the disabled reset value and checks that no output moves. It then programs the register and expects the latched level to appear on the newly selected output. The wire-OR case is reached by sending two devices with different slot/pin pairs to two lines that share one output. One line is then released while the other holds the output high. A third case has two devices report on the same line with opposite levels, to check that the latest report wins.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NL     = 4,
  parameter int NO     = 16,
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter logic [7:0] BASE = 8'h60,
  parameter logic [7:0] RST_ROUTE = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic [7:0]              evt_devfn,
  input  logic [$clog2(NL)-1:0]   evt_pin,
  input  logic                    evt_level,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [DW-1:0]           cfg_wdata,
  output logic [DW-1:0]           cfg_rdata,
  output logic [NO-1:0]           irq_out
);
  localparam int LW = $clog2(NL);
  localparam int OW = $clog2(NO);
  localparam int SLOT_LSB = 3;

  logic [NL-1:0][DW-1:0] route_q;
  logic [NL-1:0]         lvl_q;
  logic [LW-1:0]         line;
  logic [AW-1:0]         off;
  logic                  in_rng;

  assign line   = evt_pin + evt_devfn[SLOT_LSB +: LW] - LW'(1);
  assign off    = cfg_addr - AW'(BASE);
  assign in_rng = off < AW'(NL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) route_q[i] <= DW'(RST_ROUTE);
      lvl_q <= '0;
    end else begin
      if (cfg_we && in_rng) route_q[off[LW-1:0]] <= cfg_wdata;
      if (evt_valid) lvl_q[line] <= evt_level;
    end
  end

  assign cfg_rdata = in_rng ? route_q[off[LW-1:0]] : '0;

  for (genvar k = 0; k < NO; k++) begin : g_out
    logic [NL-1:0] hit;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      assign hit[i] = lvl_q[i] && (route_q[i] < DW'(NO)) && (route_q[i][OW-1:0] == OW'(k));
    end
    assign irq_out[k] = |hit;
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            evt_valid,
  input logic [7:0]      evt_devfn,
  input logic [1:0]      evt_pin,
  input logic            evt_level,
  input logic            cfg_we,
  input logic [7:0]      cfg_addr,
  input logic [7:0]      cfg_wdata,
  input logic [7:0]      cfg_rdata,
  input logic [15:0]     irq_out,
  input logic [3:0][7:0] route_q
);
  logic [1:0] ln;
  logic [7:0] sel;
  logic       in_rng;
  assign ln     = 2'(evt_pin + evt_devfn[4:3] + 2'd3);
  assign sel    = route_q[ln];
  assign in_rng = cfg_addr >= 8'h60 && cfg_addr <= 8'h63;

  always @(negedge clk)
    if (!rst_n) a_reset_clear_r4: assert (irq_out == '0);

  p_report_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_level && !cfg_we && sel < 8'd16 |=> irq_out[$past(sel[3:0])]);

  p_quiet_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid && !cfg_we |=> $stable(irq_out));

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && in_rng |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)));

  p_wire_or_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= 4);
endmodule

bind pirq_router pirq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_devfn(evt_devfn),
  .evt_pin(evt_pin), .evt_level(evt_level), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq_out), .route_q(route_q)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_level = 1'b0, cfg_we = 1'b0;
  logic [7:0] evt_devfn = '0, cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic [1:0] evt_pin = '0;
  logic [15:0] irq_out;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pirq_router u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report(input logic [7:0] devfn, input logic [1:0] pin, input logic lvl);
    @(negedge clk);
    evt_valid = 1'b1; evt_devfn = devfn; evt_pin = pin; evt_level = lvl;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a; #1;
    chk(req, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  task automatic t_reset;
    chk("R4 out", irq_out, 16'h0);
    for (int i = 0; i < 4; i++) rd_chk("R4 route", 8'h60 + 8'(i), 8'h80);
  endtask

  task automatic t_regs;
    wr(8'h60, 8'h05); wr(8'h61, 8'h09); wr(8'h62, 8'h05);
    rd_chk("R2 0x60", 8'h60, 8'h05);
    rd_chk("R2 0x61", 8'h61, 8'h09);
    rd_chk("R2 0x62", 8'h62, 8'h05);
    rd_chk("R2 0x63", 8'h63, 8'h80);
    wr(8'h64, 8'h33); wr(8'h5F, 8'h44);
    rd_chk("R3 read 0x64", 8'h64, 8'h00);
    rd_chk("R3 read 0x5F", 8'h5F, 8'h00);
    for (int i = 0; i < 4; i++)
      rd_chk("R3 untouched", 8'h60 + 8'(i), (i == 0 || i == 2) ? 8'h05 : (i == 1) ? 8'h09 : 8'h80);
  endtask

  task automatic t_slot_map;
    report(8'h08, 2'd0, 1'b1);
    chk("R1 slot1 INTA->line0", irq_out, 16'h0020);
    report(8'h08, 2'd0, 1'b0);
    chk("R7 release", irq_out, 16'h0);
    report(8'h11, 2'd0, 1'b1);
    chk("R1 slot2 INTA->line1", irq_out, 16'h0200);
    report(8'h11, 2'd0, 1'b0);
    report(8'h1F, 2'd3, 1'b1);
    chk("R1 slot3 INTD->line1", irq_out, 16'h0200);
    report(8'h1F, 2'd3, 1'b0);
    report(8'h00, 2'd0, 1'b1);
    chk("R5 slot0 INTA->line3 disabled", irq_out, 16'h0);
  endtask

  task automatic t_wire_or;
    report(8'h08, 2'd0, 1'b1);
    report(8'h28, 2'd2, 1'b1);
    chk("R6 both on irq5", irq_out, 16'h0020);
    report(8'h08, 2'd0, 1'b0);
    chk("R6 one held", irq_out, 16'h0020);
    report(8'h28, 2'd2, 1'b0);
    chk("R6 both released", irq_out, 16'h0);
  endtask

  task automatic t_shared_last;
    report(8'h08, 2'd1, 1'b1);
    chk("R7 line1 set", irq_out, 16'h0200);
    report(8'h10, 2'd0, 1'b0);
    chk("R7 last report wins", irq_out, 16'h0);
    report(8'h10, 2'd0, 1'b1);
  endtask

  task automatic t_reroute;
    wr(8'h61, 8'h0C);
    chk("R8 moved to 12", irq_out, 16'h1000);
    wr(8'h61, 8'h0F);
    chk("R5 route 15", irq_out, 16'h8000);
    wr(8'h61, 8'h10);
    chk("R5 0x10 disables", irq_out, 16'h0);
    wr(8'h63, 8'h03);
    chk("R8 latched disabled line appears", irq_out, 16'h0008);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_slot_map();
    t_wire_or();
    t_shared_last();
    t_reroute();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule